// File: doc/BRIEF.md
# Line Interface Built-In Test Monitor

This block supervises one channel of a coaxial line transceiver that carries CMI-coded data. It runs on a clock at the line bit rate. It watches three sampled bit streams for activity: the transmit input, the transmit line output and the receive output. It also takes a loss-of-signal flag from an external amplitude detector. From these it forms one pass/fail verdict, which it drives on a complementary status pair.

Each monitored stream is judged only by its transitions. A stream counts as dead once it has gone more than `IDLE_LIMIT` (default 100) bit periods without changing level. Its fault clears at the first transition after that.

The block also holds the receive-side output selector. A loopback control routes the transmit data to the receive output in place of the equalised receive data. An enable control, when low, forces the positive receive output low.

Top module: `line_bist_monitor`

## Requirements
- R1: A stream that changes level at least once in every window of `IDLE_LIMIT` bit periods never contributes a fault.
- R2: After an idle run of more than `IDLE_LIMIT` (default 100) bit periods, a stream's fail flag rises and forces the status to fail. With 95 idle periods the status is still pass.
- R3: The overall fault is the OR of the three stream fail flags and the loss-of-signal condition. Any single one of them alone forces the status to fail.
- R4: `status_p` is 1 for pass and 0 for fail, and `status_n` is always its complement. Both come from registers, and the verdict takes effect on the clock edge after the synchronised condition.
- R5: `los_n` is active low: a 0 on it means loss detected. After its two-stage synchroniser, a 0 forces the status to fail, and a 1 releases it.
- R6: The receive output is combinational. With `loop_en` = 1, `rx_out_p` equals `tx_data`. With `loop_en` = 0, `rx_out_p` equals `rx_eq_data`. `rx_out_n` is always the complement of `rx_out_p`.
- R7: With `rx_oe` = 0, `rx_out_p` is 0 (and `rx_out_n` is 1), whatever `loop_en` selects.
- R8: A synchronous active-low reset clears all idle counters and fail flags. It drives `status_p` = 1 and `status_n` = 0.
- R9: A failed stream's flag clears on its first transition. With the other inputs healthy, the status returns to pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_tx_in | input | 1 | Sampled transmit input stream (monitored) |
| mon_tx_line | input | 1 | Sampled transmit line output stream (monitored) |
| mon_rx_out | input | 1 | Sampled receive output stream (monitored) |
| los_n | input | 1 | Loss-of-signal from amplitude detector, 0 = loss |
| tx_data | input | 1 | Transmit channel data, used for loopback |
| rx_eq_data | input | 1 | Equalised receive data |
| loop_en | input | 1 | 1 = loop transmit data to receive output |
| rx_oe | input | 1 | 0 = force positive receive output low |
| rx_out_p | output | 1 | Receive output, positive |
| rx_out_n | output | 1 | Receive output, negative |
| status_p | output | 1 | Test status, 1 = pass |
| status_n | output | 1 | Test status complement |

## Verification
The bench goes after the idle boundary: it holds one stream still for 95 periods and for 110 periods. A design that compared with `>=` or counted from the wrong pipeline stage shows up there, because the model is compared on every clock and disagrees by one cycle. Each stream and the loss flag are faulted alone. A design that left one term out of the OR, or that took `los_n` as active high, would keep reporting pass, or would report fail after reset. Resuming toggling checks that a flag drops on the first edge, where a sticky flag would leave the status stuck at fail. All four combinations of loopback and enable are driven against random data. This catches an inverted select, or an enable that gates only one output leg.

// File: rtl/lbm_pkg.sv
// Package: shared constants for the line interface built-in test monitor.
// Assumes three monitored streams in the fixed order below.
package lbm_pkg;
    localparam int NUM_STREAMS = 3;

    // Index of each monitored stream inside the fail vector.
    typedef enum logic [1:0] {
        STRM_TX_IN   = 2'd0,
        STRM_TX_LINE = 2'd1,
        STRM_RX_OUT  = 2'd2
    } stream_e;

    // Width needed to hold a saturating idle count of limit+1.
    function automatic int idle_cnt_width(input int limit);
        return $clog2(limit + 2);
    endfunction
endpackage

// File: rtl/lbm_sync.sv
// Module: two-flop synchroniser with a selectable reset level.
// Assumes the input is asynchronous to clk and the reset is synchronous and active low.
module lbm_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic stage1;
    logic stage2;

    // Shift the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_in;
            stage2 <= stage1;
        end
    end

    assign q_out = stage2;
endmodule

// File: rtl/lbm_activity_det.sv
// Module: transition-based activity detector for one bit stream.
// It synchronises the stream, flags an edge whenever the sample differs from the one before,
// and counts idle bit periods in a saturating counter. The fail flag is high while the
// count exceeds IDLE_LIMIT. Assumes one sample per clock.
module lbm_activity_det #(
    parameter int IDLE_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic edge_seen,
    output logic fail
);
    import lbm_pkg::*;

    localparam int CW = idle_cnt_width(IDLE_LIMIT);
    localparam logic [CW-1:0] SAT_VAL = CW'(IDLE_LIMIT + 1);

    logic          bit_sync;
    logic          bit_prev;
    logic [CW-1:0] idle_cnt;

    lbm_sync #(.RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (bit_in),
        .q_out (bit_sync)
    );

    // Hold the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_prev <= 1'b0;
        else        bit_prev <= bit_sync;
    end

    assign edge_seen = bit_sync ^ bit_prev;

    // Count idle periods, clear on an edge, saturate one past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                idle_cnt <= '0;
        else if (edge_seen)        idle_cnt <= '0;
        else if (idle_cnt != SAT_VAL) idle_cnt <= idle_cnt + 1'b1;
    end

    assign fail = (idle_cnt == SAT_VAL);
endmodule

// File: rtl/lbm_rx_select.sv
// Module: receive output selector with loopback and forced-low enable.
// Purely combinational. Assumes the negative leg is the complement of the positive leg.
module lbm_rx_select (
    input  logic tx_data,
    input  logic rx_eq_data,
    input  logic loop_en,
    input  logic rx_oe,
    output logic rx_out_p,
    output logic rx_out_n
);
    logic chosen;

    // Pick the data source, then apply the enable.
    always_comb begin
        chosen   = loop_en ? tx_data : rx_eq_data;
        rx_out_p = rx_oe & chosen;
        rx_out_n = ~rx_out_p;
    end
endmodule

// File: rtl/lbm_status.sv
// Module: combines stream fail flags with the loss condition into a registered status pair.
// Assumes los_ok is already synchronised and is 1 when the signal is present.
module lbm_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fail_vec,
    input  logic         los_ok,
    output logic         status_p,
    output logic         status_n
);
    logic fault;

    // OR all fault terms; the loss term is made active high here.
    assign fault = (|fail_vec) | ~los_ok;

    // Register the status pair so that it cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_p <= 1'b1;
            status_n <= 1'b0;
        end else begin
            status_p <= ~fault;
            status_n <= fault;
        end
    end
endmodule

// File: rtl/line_bist_monitor.sv
// Module: top of the line interface built-in test monitor for one channel.
// It instantiates one activity detector per monitored stream, synchronises the loss
// flag, forms the status pair and holds the receive selector.
// Assumes all inputs are sampled at the bit rate and the reset is synchronous and active low.
module line_bist_monitor #(
    parameter int IDLE_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_tx_in,
    input  logic mon_tx_line,
    input  logic mon_rx_out,
    input  logic los_n,
    input  logic tx_data,
    input  logic rx_eq_data,
    input  logic loop_en,
    input  logic rx_oe,
    output logic rx_out_p,
    output logic rx_out_n,
    output logic status_p,
    output logic status_n
);
    import lbm_pkg::*;

    logic [NUM_STREAMS-1:0] mon_vec;
    logic [NUM_STREAMS-1:0] edge_vec;
    logic [NUM_STREAMS-1:0] fail_vec;
    logic                   los_sync;

    // Gather the monitored streams into a vector in stream_e order.
    always_comb begin
        mon_vec               = '0;
        mon_vec[STRM_TX_IN]   = mon_tx_in;
        mon_vec[STRM_TX_LINE] = mon_tx_line;
        mon_vec[STRM_RX_OUT]  = mon_rx_out;
    end

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_det
        lbm_activity_det #(.IDLE_LIMIT(IDLE_LIMIT)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_in    (mon_vec[g]),
            .edge_seen (edge_vec[g]),
            .fail      (fail_vec[g])
        );
    end

    lbm_sync #(.RST_VAL(1'b1)) u_los_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (los_n),
        .q_out (los_sync)
    );

    lbm_status #(.N(NUM_STREAMS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .fail_vec (fail_vec),
        .los_ok   (los_sync),
        .status_p (status_p),
        .status_n (status_n)
    );

    lbm_rx_select u_rx_sel (
        .tx_data    (tx_data),
        .rx_eq_data (rx_eq_data),
        .loop_en    (loop_en),
        .rx_oe      (rx_oe),
        .rx_out_p   (rx_out_p),
        .rx_out_n   (rx_out_n)
    );
endmodule

// File: rtl/lbm_checker.sv
// Module: assertion checker bound to line_bist_monitor.
// Assumes the internal vectors edge_vec, fail_vec and los_sync exist in the top module.
module lbm_checker #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] edge_vec,
    input logic [N-1:0] fail_vec,
    input logic         los_sync,
    input logic         rx_oe,
    input logic         loop_en,
    input logic         tx_data,
    input logic         rx_eq_data,
    input logic         rx_out_p,
    input logic         rx_out_n,
    input logic         status_p,
    input logic         status_n
);
    // R3 / R5: any fault term gives a fail on the next edge.
    p_fault_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fail_vec) || !los_sync) |=> !status_p);

    // R4: no fault terms give a pass on the next edge.
    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|fail_vec) && los_sync) |=> status_p);

    // R4: the status legs are complementary.
    p_status_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_n == !status_p);

    // R8: while reset is held, the status reads pass on the following edge.
    p_reset_pass_r8: assert property (@(posedge clk)
        !rst_n |=> (status_p && !status_n));

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R9: an edge clears the fail flag of its stream.
        p_edge_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            edge_vec[g] |=> !fail_vec[g]);
        // R2: a fail flag only rises after a cycle without an edge.
        p_rise_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fail_vec[g]) |-> !$past(edge_vec[g]));
    end

    // R6 / R7: the receive output follows the selector rules.
    always_comb begin
        if (rx_oe === 1'b0)
            p_oe_low_r7: assert (rx_out_p == 1'b0);
        if (rx_oe === 1'b1 && loop_en === 1'b1 && tx_data !== 1'bx)
            p_loop_r6: assert (rx_out_p == tx_data);
        if (rx_oe === 1'b1 && loop_en === 1'b0 && rx_eq_data !== 1'bx)
            p_normal_r6: assert (rx_out_p == rx_eq_data);
        if (rx_out_p !== 1'bx)
            p_rx_pair_r6: assert (rx_out_n == !rx_out_p);
    end
endmodule

bind line_bist_monitor lbm_checker #(.N(lbm_pkg::NUM_STREAMS)) u_lbm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_vec   (edge_vec),
    .fail_vec   (fail_vec),
    .los_sync   (los_sync),
    .rx_oe      (rx_oe),
    .loop_en    (loop_en),
    .tx_data    (tx_data),
    .rx_eq_data (rx_eq_data),
    .rx_out_p   (rx_out_p),
    .rx_out_n   (rx_out_n),
    .status_p   (status_p),
    .status_n   (status_n)
);

// File: tb/test_line_bist_monitor.sv
// Bench: behavioural per-cycle reference model compared with the outputs every clock.
module test_line_bist_monitor;
    localparam int LIMIT = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_tx_in = 1'b0, mon_tx_line = 1'b0, mon_rx_out = 1'b0;
    logic los_n = 1'b1, tx_data = 1'b0, rx_eq_data = 1'b0;
    logic loop_en = 1'b0, rx_oe = 1'b1;
    logic rx_out_p, rx_out_n, status_p, status_n;

    int nchk = 0;
    int nerr = 0;
    bit tog [3] = '{1'b0, 1'b0, 1'b0};
    string st_tag = "R4";

    always #2.5 clk = ~clk;

    line_bist_monitor #(.IDLE_LIMIT(LIMIT)) i_line_bist_monitor (
        .clk(clk), .rst_n(rst_n),
        .mon_tx_in(mon_tx_in), .mon_tx_line(mon_tx_line), .mon_rx_out(mon_rx_out),
        .los_n(los_n), .tx_data(tx_data), .rx_eq_data(rx_eq_data),
        .loop_en(loop_en), .rx_oe(rx_oe),
        .rx_out_p(rx_out_p), .rx_out_n(rx_out_n),
        .status_p(status_p), .status_n(status_n)
    );

    // Reference model: a sample history per stream and an idle run length.
    int  hist [3][3];
    int  idle [3];
    int  los_h [2];
    bit  m_pass = 1'b1;

    always @(posedge clk) begin
        bit flt;
        int cur [3];
        cur[0] = mon_tx_in; cur[1] = mon_tx_line; cur[2] = mon_rx_out;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                for (int j = 0; j < 3; j++) hist[i][j] = 0;
                idle[i] = 0;
            end
            los_h[0] = 1; los_h[1] = 1;
            m_pass = 1'b1;
        end else begin
            flt = (los_h[1] == 0);
            for (int i = 0; i < 3; i++) if (idle[i] > LIMIT) flt = 1'b1;
            m_pass = !flt;
            for (int i = 0; i < 3; i++) begin
                if (hist[i][1] != hist[i][2]) idle[i] = 0;
                else if (idle[i] <= LIMIT) idle[i] = idle[i] + 1;
                hist[i][2] = hist[i][1];
                hist[i][1] = hist[i][0];
                hist[i][0] = cur[i];
            end
            los_h[1] = los_h[0];
            los_h[0] = los_n;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // One clock: compare status, drive new inputs, compare the combinational selector.
    task automatic step();
        logic sel;
        @(negedge clk);
        chk(st_tag, status_p, m_pass);
        chk("R4", status_n, !m_pass);
        if (tog[0]) mon_tx_in = ~mon_tx_in;
        if (tog[1]) mon_tx_line = ~mon_tx_line;
        if (tog[2]) mon_rx_out = ~mon_rx_out;
        tx_data = 1'($urandom);
        rx_eq_data = 1'($urandom);
        #1;
        sel = loop_en ? tx_data : rx_eq_data;
        chk(rx_oe ? "R6" : "R7", rx_out_p, rx_oe & sel);
        chk("R6", rx_out_n, !(rx_oe & sel));
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        steps(4);
        @(negedge clk);
        chk("R8", status_p, 1'b1);
        chk("R8", status_n, 1'b0);
        rst_n = 1'b1;
        tog = '{1'b1, 1'b1, 1'b1};
        st_tag = "R1";
        steps(60);
        chk("R1", status_p, 1'b1);

        // Idle boundary on each stream alone.
        for (int s = 0; s < 3; s++) begin
            tog[s] = 1'b0;
            st_tag = "R2";
            steps(95);
            chk("R2", status_p, 1'b1);
            steps(15);
            chk("R3", status_p, 1'b0);
            tog[s] = 1'b1;
            st_tag = "R9";
            steps(5);
            chk("R9", status_p, 1'b1);
        end

        // Loss of signal alone.
        st_tag = "R5";
        los_n = 1'b0;
        steps(4);
        chk("R5", status_p, 1'b0);
        los_n = 1'b1;
        steps(4);
        chk("R5", status_p, 1'b1);

        // Selector: all control combinations.
        st_tag = "R4";
        for (int c = 0; c < 4; c++) begin
            loop_en = c[0];
            rx_oe = c[1];
            steps(12);
        end
        rx_oe = 1'b0;
        steps(3);
        chk("R7", rx_out_p, 1'b0);
        rx_oe = 1'b1;

        // Reset clears a fault in progress.
        tog = '{1'b0, 1'b0, 1'b0};
        st_tag = "R3";
        steps(110);
        chk("R3", status_p, 1'b0);
        rst_n = 1'b0;
        steps(2);
        chk("R8", status_p, 1'b1);
        rst_n = 1'b1;
        tog = '{1'b1, 1'b1, 1'b1};
        st_tag = "R8";
        steps(20);
        chk("R8", status_p, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule